// File: doc/BRIEF.md
# Integer Compare, Byte-Find and Leading-Zero Unit

This block is an integer helper for a 32-bit soft processor. It takes two operands, `a` and `b`, and a two-bit operation code. From them it produces one 32-bit result. There are four operations: a signed ordering compare, an unsigned ordering compare, a search for the first equal byte lane, and a count of the leading zero bits of `a`. All of the arithmetic is combinational. A single output register captures the result whenever `in_valid` is high, and it raises `out_valid` in the same edge.

Each compare returns the difference `b - a`. When the operands have opposite signs, bit 31 of that difference is overwritten so that it gives the correct ordering. In the signed compare it takes the sign of `b`. In the unsigned compare it takes the top bit of `a`. Bit 31 of the result can therefore be used directly as a "less than" flag.

The byte search scans the lanes from the most significant lane downward. It returns the 1-based position of the first lane in which `a` and `b` agree, or 0 when no lane agrees. A pipeline stage that needs a compare, string-scan or normalisation value issues one request per cycle and reads the result one cycle later.

Top module: `int_helper_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `result` to 0 and `out_valid` to 0 at the next rising edge. Reset takes priority over a simultaneous `in_valid`.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `result` holds the value of the operation sampled at that edge. When `in_valid` is low, `out_valid` is low after the edge and `result` keeps its previous value.
- R3: Operation code 2'b00 (signed compare) returns `b + ~a + 1`. When `a[31]` differs from `b[31]`, bit 31 is replaced by `b[31]` and bits 30:0 keep the difference.
- R4: Operation code 2'b01 (unsigned compare) returns `b + ~a + 1`. When `a[31]` differs from `b[31]`, bit 31 is replaced by `a[31]`.
- R5: Operation code 2'b10 (byte-find) numbers the lanes as follows: bits 31:24 are lane 1, 23:16 lane 2, 15:8 lane 3 and 7:0 lane 4. It returns the lowest-numbered lane in which `a` and `b` are equal, so an earlier match takes precedence over any later one.
- R6: Byte-find returns 0 when no lane of `a` equals the same lane of `b`.
- R7: Operation code 2'b11 returns the number of leading zero bits of `a`, from 0 to 31. It returns 32 when `a` is zero. `b` has no effect on this result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_valid | input | 1 | Request strobe; operands and code are captured at the edge |
| op | input | 2 | Operation code: 00 signed compare, 01 unsigned compare, 10 byte-find, 11 leading zeros |
| a | input | 32 | First operand (subtrahend, scanned operand, count source) |
| b | input | 32 | Second operand (minuend, search pattern) |
| out_valid | output | 1 | High for one cycle after each accepted request |
| result | output | 32 | Registered result of the last accepted request |

## Verification
Two functions can fall in the same cycle. The first pair is reset and a new request: the bench raises `rst` while `in_valid` is high with operands that would give a non-zero result. It then expects zero on both `result` and `out_valid`. The second pair is the subtraction and the sign correction in a compare whose operands have opposite signs. Here the bench drives pairs that straddle the sign boundary and compares the whole word, including the overwritten bit 31, against its own model. For byte-find, the bench builds patterns in which several lanes match at once, and checks that the earliest lane wins.

// File: rtl/int_helper_pkg.sv
package int_helper_pkg;

  typedef enum logic [1:0] {
    OP_SCMP = 2'b00,
    OP_UCMP = 2'b01,
    OP_FIND = 2'b10,
    OP_CLZ  = 2'b11
  } opCode_t;

  typedef struct packed {
    logic    loadEn;
    logic    clearEn;
    opCode_t opSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/int_helper_ctrl.sv
module int_helper_ctrl
  import int_helper_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [1:0]   opIn,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  always_comb begin
    strobes.clearEn = rst;
    strobes.loadEn  = inValid && !rst;
    strobes.opSel   = opCode_t'(opIn);
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/int_helper_dpath.sv
module int_helper_dpath
  import int_helper_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resultQ
);

  localparam int LANES = DATA_W / LANE_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] diff;
  logic              signDiff;
  logic [DATA_W-1:0] signedCmp;
  logic [DATA_W-1:0] unsignedCmp;
  logic [LANES-1:0]  laneEq;
  logic [DATA_W-1:0] findIdx;
  logic [DATA_W-1:0] zeroCnt;
  logic [DATA_W-1:0] resultD;

  assign diff     = opB + ~opA + DATA_W'(1);
  assign signDiff = opA[MSB] ^ opB[MSB];

  always_comb begin
    signedCmp   = diff;
    unsignedCmp = diff;
    if (signDiff) begin
      signedCmp[MSB]   = opB[MSB];
      unsignedCmp[MSB] = opA[MSB];
    end
  end

  // laneEq[0] is the most significant lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneEq[g] = opA[MSB - g*LANE_W -: LANE_W] == opB[MSB - g*LANE_W -: LANE_W];
  end

  always_comb begin
    findIdx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (laneEq[i]) findIdx = DATA_W'(i + 1);
    end
  end

  always_comb begin
    zeroCnt = DATA_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (opA[i]) zeroCnt = DATA_W'(DATA_W - 1 - i);
    end
  end

  always_comb begin
    unique case (strobes.opSel)
      OP_SCMP: resultD = signedCmp;
      OP_UCMP: resultD = unsignedCmp;
      OP_FIND: resultD = findIdx;
      OP_CLZ:  resultD = zeroCnt;
      default: resultD = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.clearEn)     resultQ <= '0;
    else if (strobes.loadEn) resultQ <= resultD;
  end

endmodule

// File: rtl/int_helper_unit.sv
module int_helper_unit
  import int_helper_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  ctrlStrobes_t strobes;

  int_helper_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (in_valid),
    .opIn     (op),
    .strobes  (strobes),
    .outValid (out_valid)
  );

  int_helper_dpath #(.DATA_W(DATA_W), .LANE_W(LANE_W)) uDpath (
    .clk     (clk),
    .strobes (strobes),
    .opA     (a),
    .opB     (b),
    .resultQ (result)
  );

endmodule

// File: rtl/int_helper_checker.sv
module int_helper_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_scmp_sign_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00 && (a[DATA_W-1] != b[DATA_W-1]))
      |=> result[DATA_W-1] == $past(b[DATA_W-1]));

  assert_ucmp_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01 && (a[DATA_W-1] != b[DATA_W-1]))
      |=> result[DATA_W-1] == $past(a[DATA_W-1]));

  assert_find_top_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10 && a[DATA_W-1 -: 8] == b[DATA_W-1 -: 8])
      |=> result == DATA_W'(1));

  assert_find_none_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10 && (a ^ b) == '1) |=> result == '0);

  assert_clz_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11 && a == '0) |=> result == DATA_W'(DATA_W));

  assert_clz_top_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11 && a[DATA_W-1]) |=> result == '0);

endmodule

bind int_helper_unit int_helper_checker #(.DATA_W(DATA_W)) uChecker (.*);

// File: tb/int_helper_unit_test.sv
`timescale 1ns/1ps
module int_helper_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  int_helper_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .a(a), .b(b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] modelCmp(input logic [31:0] x, input logic [31:0] y,
                                           input logic isSigned);
    logic [31:0] t;
    t = y - x;
    if (x[31] != y[31]) t[31] = isSigned ? y[31] : x[31];
    return t;
  endfunction

  function automatic logic [31:0] modelFind(input logic [31:0] x, input logic [31:0] y);
    for (int i = 0; i < 4; i++)
      if (x[31-8*i -: 8] == y[31-8*i -: 8]) return 32'(i + 1);
    return 32'd0;
  endfunction

  function automatic logic [31:0] modelClz(input logic [31:0] x);
    for (int i = 31; i >= 0; i--)
      if (x[i]) return 32'(31 - i);
    return 32'd32;
  endfunction

  function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] x,
                                        input logic [31:0] y);
    case (o)
      2'b00:   return modelCmp(x, y, 1'b1);
      2'b01:   return modelCmp(x, y, 1'b0);
      2'b10:   return modelFind(x, y);
      default: return modelClz(x);
    endcase
  endfunction

  function automatic string tagOf(input logic [1:0] o, input logic [31:0] x,
                                  input logic [31:0] y);
    case (o)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return (modelFind(x, y) == 0) ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op = o; a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 out_valid", 32'(out_valid), 32'd1);
    check(tagOf(o, x, y), result, model(o, x, y));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    logic [31:0] ra, rb;
    logic [1:0]  ro;
    void'($urandom(32'h1234_5678));

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset result", result, 32'd0);
    check("R1 reset out_valid", 32'(out_valid), 32'd0);
    rst = 1'b0;

    // R3 signed compare corners
    issue(2'b00, 32'd5, 32'd3);
    issue(2'b00, 32'hFFFF_FFFF, 32'd1);
    issue(2'b00, 32'd1, 32'hFFFF_FFFF);
    issue(2'b00, 32'h8000_0000, 32'h7FFF_FFFF);
    issue(2'b00, 32'h1234_5678, 32'h1234_5678);
    // R4 unsigned compare corners
    issue(2'b01, 32'hFFFF_FFFF, 32'd1);
    issue(2'b01, 32'd1, 32'h8000_0000);
    issue(2'b01, 32'h7FFF_FFFF, 32'h8000_0000);
    // R5 byte-find, multiple matches and single lanes
    issue(2'b10, 32'hAA11_22AA, 32'hAA00_00AA);
    issue(2'b10, 32'h0011_2233, 32'hFF11_0033);
    issue(2'b10, 32'h0011_2233, 32'hFFEE_2200);
    issue(2'b10, 32'h0011_2233, 32'hFFEE_DD33);
    // R6 no match
    issue(2'b10, 32'h0011_2233, 32'hFFEE_DDCC);
    // R7 leading zeros, b ignored
    issue(2'b11, 32'd0, 32'hFFFF_FFFF);
    issue(2'b11, 32'd0, 32'd0);
    issue(2'b11, 32'h8000_0000, 32'd7);
    issue(2'b11, 32'd1, 32'h1234_5678);
    issue(2'b11, 32'h0001_0000, 32'd0);

    // R2 idle cycle holds result
    held = result;
    @(negedge clk);
    op = 2'b00; a = 32'd9; b = 32'd100; in_valid = 1'b0;
    @(negedge clk);
    check("R2 idle out_valid", 32'(out_valid), 32'd0);
    check("R2 idle hold", result, held);

    // R1 reset collides with a request
    @(negedge clk);
    op = 2'b00; a = 32'd1; b = 32'd50; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 collide result", result, 32'd0);
    check("R1 collide out_valid", 32'(out_valid), 32'd0);
    rst = 1'b0; in_valid = 1'b0;

    // random mix
    for (int n = 0; n < 400; n++) begin
      ro = 2'($urandom_range(0, 3));
      ra = $urandom;
      rb = $urandom;
      if (ro == 2'b10) begin
        for (int l = 0; l < 4; l++)
          if ($urandom_range(0, 2) == 0) rb[8*l +: 8] = ra[8*l +: 8];
      end
      if (ro == 2'b11) ra = ra >> $urandom_range(0, 32);
      issue(ro, ra, rb);
    end

    finish_run();
  end

endmodule